// File: doc/BRIEF.md
# Phase and Frequency Discriminator

This block accepts a stream of phase words, one per valid-qualified clock. A typical source is the angle output of a rectangular-to-polar converter. Each accepted word is first multiplied by 1, 2, 4 or 8 through a left shift that drops the bits carried out of the top. This folds the circle so that PSK symbol jumps of 180, 90 or 45 degrees disappear. The folded phase is stored in a short history. From that history the block forms a frequency estimate: the signed change of phase across a programmable span of 1 to 8 accepted samples.

The main output carries either the folded phase or the phase change, chosen by a select input. A separate rate output can be switched on to deliver the phase change on every accepted sample, whatever the main output is showing. All results are 18 bits wide. Each one appears one clock after the input sample that produced it. No phase change is ever issued until enough samples have arrived to fill the chosen span.

Top module: `phaseDisc`

## Requirements
- R1: While reset is asserted and after it is released, with no valid input, `outValid` and `rateValid` are 0.
- R2: The folded phase equals `inPhase` shifted left by `shiftSel` bit positions (code 0..3 gives a shift of 0..3), keeping the low 18 bits. The vacated low bits are zero.
- R3: With `outSel` = 0, every valid input produces `outValid` = 1 exactly one clock later, with `outData` holding the folded phase. This holds from the very first sample after reset.
- R4: With `outSel` = 1, `outData` holds the folded phase of the current sample minus the folded phase of the sample D accepted samples earlier, computed modulo 2^18. D is `delaySel` + 1, so code 0 gives 1 sample and code 7 gives 8 samples.
- R5: The difference is read as an 18-bit two's-complement value, so a step across the wrap point gives the shortest signed change. From 0x3FFF0 to 0x00010 the result is 0x00020; from 0x00010 to 0x3FFF0 it is 0x3FFE0.
- R6: Counting accepted samples from 0 after reset, sample k issues a phase change (on `outData` with `outSel` = 1, or on `rateData`) only when k >= D. Otherwise the corresponding valid output stays 0.
- R7: Cycles with `inValid` = 0 do not advance the history, produce no output and do not count toward the span.
- R8: With `strobeEn` = 1, each valid sample with k >= D produces `rateValid` = 1 one clock later, with `rateData` holding the R4 difference, for either value of `outSel`. With `strobeEn` = 0, `rateValid` stays 0.
- R9: The history stores folded values. A difference therefore uses the shift that was in effect when each of the two samples was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Phase sample present this cycle |
| inPhase | input | 18 | Phase sample, full circle = 2^18 |
| shiftSel | input | 2 | Fold shift, 0..3 bit positions |
| delaySel | input | 3 | Difference span minus one |
| outSel | input | 1 | 1: main output carries phase change, 0: folded phase |
| strobeEn | input | 1 | Enable the per-sample rate output |
| outValid | output | 1 | Main result valid |
| outData | output | 18 | Main result |
| rateValid | output | 1 | Rate result valid |
| rateData | output | 18 | Phase change per span |

## Verification
The hardest situation to reach is a difference whose two operands were accepted under different fold settings, or were separated by idle cycles, at the longest span. Only a run of many valid samples with control changes between them reaches it. The bench keeps its own history of folded values indexed by accepted sample, not by clock. It drives back-to-back samples, inserts idle gaps, changes `shiftSel` mid-stream and uses span code 7. It also lines up samples so that the difference crosses the wrap point in both directions.

// File: rtl/phaseDiscPkg.sv
package phaseDiscPkg;

  // Strobes from the control side to the datapath for one accepted sample
  typedef struct packed {
    logic advance;   // accept the sample into the history
    logic emitMain;  // register a result onto the main output
    logic emitRate;  // register a result onto the rate output
    logic selDiff;   // main output carries the difference
  } discStrobes_t;

endpackage

// File: rtl/phaseDiscCtrl.sv
module phaseDiscCtrl
  import phaseDiscPkg::*;
#(
  parameter int MAX_DELAY = 8,
  parameter int DELAY_W   = $clog2(MAX_DELAY)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DELAY_W-1:0] delaySel,
  input  logic               outSel,
  input  logic               strobeEn,
  output discStrobes_t       strobes
);

  localparam int CNT_W = $clog2(MAX_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_DELAY);

  // Number of samples already held in the history, saturating at its depth
  logic [CNT_W-1:0] heldCount;
  logic             primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCount <= '0;
    end else if (inValid && (heldCount != CNT_MAX)) begin
      heldCount <= heldCount + 1'b1;
    end
  end

  // The span is delaySel+1, so primed means heldCount >= delaySel+1
  assign primed = heldCount > CNT_W'(delaySel);

  always_comb begin
    strobes.advance  = inValid;
    strobes.selDiff  = outSel;
    strobes.emitMain = inValid && (!outSel || primed);
    strobes.emitRate = inValid && strobeEn && primed;
  end

endmodule

// File: rtl/phaseDiscDatapath.sv
module phaseDiscDatapath
  import phaseDiscPkg::*;
#(
  parameter int PHASE_W   = 18,
  parameter int MAX_DELAY = 8,
  parameter int SHIFT_MAX = 3,
  parameter int DELAY_W   = $clog2(MAX_DELAY),
  parameter int SHIFT_W   = $clog2(SHIFT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  discStrobes_t       strobes,
  input  logic [PHASE_W-1:0] inPhase,
  input  logic [SHIFT_W-1:0] shiftSel,
  input  logic [DELAY_W-1:0] delaySel,
  output logic               outValid,
  output logic [PHASE_W-1:0] outData,
  output logic               rateValid,
  output logic [PHASE_W-1:0] rateData
);

  logic [PHASE_W-1:0] foldedPhase;
  logic [PHASE_W-1:0] pastPhase;
  logic [PHASE_W-1:0] phaseDelta;
  logic [PHASE_W-1:0] history [MAX_DELAY];

  // Fold: shift left, drop overflow bits at the top
  always_comb begin
    foldedPhase = inPhase;
    for (int s = 1; s <= SHIFT_MAX; s++) begin
      if (int'(shiftSel) == s) begin
        foldedPhase = inPhase << s;
      end
    end
  end

  // History line; entry 0 is the most recent accepted sample
  generate
    for (genvar i = 0; i < MAX_DELAY; i++) begin : gHist
      if (i == 0) begin : gHead
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            history[0] <= '0;
          end else if (strobes.advance) begin
            history[0] <= foldedPhase;
          end
        end
      end else begin : gTail
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            history[i] <= '0;
          end else if (strobes.advance) begin
            history[i] <= history[i-1];
          end
        end
      end
    end
  endgenerate

  assign pastPhase  = history[delaySel];
  // Modular subtraction; the result reads as two's complement
  assign phaseDelta = foldedPhase - pastPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      rateValid <= 1'b0;
      rateData  <= '0;
    end else begin
      outValid  <= strobes.emitMain;
      rateValid <= strobes.emitRate;
      if (strobes.emitMain) begin
        outData <= strobes.selDiff ? phaseDelta : foldedPhase;
      end
      if (strobes.emitRate) begin
        rateData <= phaseDelta;
      end
    end
  end

endmodule

// File: rtl/phaseDisc.sv
module phaseDisc
  import phaseDiscPkg::*;
#(
  parameter int PHASE_W   = 18,
  parameter int MAX_DELAY = 8,
  parameter int SHIFT_MAX = 3,
  parameter int DELAY_W   = $clog2(MAX_DELAY),
  parameter int SHIFT_W   = $clog2(SHIFT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [PHASE_W-1:0] inPhase,
  input  logic [SHIFT_W-1:0] shiftSel,
  input  logic [DELAY_W-1:0] delaySel,
  input  logic               outSel,
  input  logic               strobeEn,
  output logic               outValid,
  output logic [PHASE_W-1:0] outData,
  output logic               rateValid,
  output logic [PHASE_W-1:0] rateData
);

  discStrobes_t strobes;

  phaseDiscCtrl #(
    .MAX_DELAY(MAX_DELAY),
    .DELAY_W  (DELAY_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .delaySel(delaySel),
    .outSel  (outSel),
    .strobeEn(strobeEn),
    .strobes (strobes)
  );

  phaseDiscDatapath #(
    .PHASE_W  (PHASE_W),
    .MAX_DELAY(MAX_DELAY),
    .SHIFT_MAX(SHIFT_MAX),
    .DELAY_W  (DELAY_W),
    .SHIFT_W  (SHIFT_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inPhase  (inPhase),
    .shiftSel (shiftSel),
    .delaySel (delaySel),
    .outValid (outValid),
    .outData  (outData),
    .rateValid(rateValid),
    .rateData (rateData)
  );

endmodule

// File: rtl/phaseDiscChecker.sv
module phaseDiscChecker #(
  parameter int PHASE_W   = 18,
  parameter int MAX_DELAY = 8,
  parameter int DELAY_W   = 3,
  parameter int SHIFT_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [PHASE_W-1:0] inPhase,
  input logic [SHIFT_W-1:0] shiftSel,
  input logic [DELAY_W-1:0] delaySel,
  input logic               outSel,
  input logic               strobeEn,
  input logic               outValid,
  input logic [PHASE_W-1:0] outData,
  input logic               rateValid,
  input logic [PHASE_W-1:0] rateData
);

  localparam int SEEN_W = $clog2(MAX_DELAY + 1) + 1;

  // Independent count of accepted samples, saturating
  logic [SEEN_W-1:0] seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen <= '0;
    end else if (inValid && (seen < SEEN_W'(MAX_DELAY))) begin
      seen <= seen + 1'b1;
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R3

  AST_PHASE_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(outSel)) |->
      (outData == PHASE_W'($past(inPhase) << $past(shiftSel)))); // R2

  AST_DIFF_PRIMED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outSel)) |-> ($past(seen) > SEEN_W'($past(delaySel)))); // R6

  AST_RATE_PRIMED: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |-> ($past(seen) > SEEN_W'($past(delaySel)))); // R6

  AST_RATE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |-> ($past(strobeEn) && $past(inValid))); // R8

  AST_RATE_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (rateValid && outValid && $past(outSel)) |-> (rateData == outData)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> (!outValid && !rateValid)); // R7

endmodule

bind phaseDisc phaseDiscChecker #(
  .PHASE_W  (PHASE_W),
  .MAX_DELAY(MAX_DELAY),
  .DELAY_W  (DELAY_W),
  .SHIFT_W  (SHIFT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inPhase  (inPhase),
  .shiftSel (shiftSel),
  .delaySel (delaySel),
  .outSel   (outSel),
  .strobeEn (strobeEn),
  .outValid (outValid),
  .outData  (outData),
  .rateValid(rateValid),
  .rateData (rateData)
);

// File: tb/tb_phaseDisc.sv
module tb_phaseDisc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [17:0] inPhase = '0;
  logic [1:0]  shiftSel = '0;
  logic [2:0]  delaySel = '0;
  logic        outSel = 1'b0;
  logic        strobeEn = 1'b0;
  logic        outValid;
  logic [17:0] outData;
  logic        rateValid;
  logic [17:0] rateData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model: folded history by accepted sample
  logic [17:0] mHist [8];
  int          mCount;

  always #10 clk = ~clk;

  phaseDisc dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPhase(inPhase),
    .shiftSel(shiftSel), .delaySel(delaySel), .outSel(outSel),
    .strobeEn(strobeEn), .outValid(outValid), .outData(outData),
    .rateValid(rateValid), .rateData(rateData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    inValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outValid in reset", 32'(outValid), 0);
    chk("R1 rateValid in reset", 32'(rateValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", 32'(outValid), 0);
    chk("R1 rateValid after reset", 32'(rateValid), 0);
    for (int i = 0; i < 8; i++) mHist[i] = '0;
    mCount = 0;
  endtask

  // Drives one sample at a falling edge; checks its result one clock later
  task automatic sendNow(input logic [17:0] p, input string tag);
    logic [17:0] folded;
    logic [17:0] diff;
    int          span;
    bit          primed;
    folded = p << shiftSel;
    span   = int'(delaySel) + 1;
    primed = mCount >= span;
    diff   = folded - mHist[span-1];
    inPhase = p;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk({tag, " outValid"}, 32'(outValid), 32'(!outSel || primed));
    if (outValid && (!outSel || primed))
      chk({tag, " outData"}, 32'(outData), 32'(outSel ? diff : folded));
    chk({tag, " rateValid"}, 32'(rateValid), 32'(strobeEn && primed));
    if (rateValid && strobeEn && primed)
      chk({tag, " rateData"}, 32'(rateData), 32'(diff));
    for (int i = 7; i > 0; i--) mHist[i] = mHist[i-1];
    mHist[0] = folded;
    if (mCount < 8) mCount++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R7 idle outValid", 32'(outValid), 0);
      chk("R7 idle rateValid", 32'(rateValid), 0);
    end
  endtask

  task automatic testFoldPhase();
    doReset();
    outSel = 1'b0; strobeEn = 1'b0; delaySel = 3'd3;
    for (int s = 0; s < 4; s++) begin
      shiftSel = 2'(s);
      sendNow(18'h2ABCD, "R2 fold");
    end
    shiftSel = 2'd3;
    sendNow(18'h3FFFF, "R2 fold top bits dropped");
    // explicit values
    shiftSel = 2'd2;
    inPhase = 18'h1_2345; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R3 phase latency", 32'(outValid), 1);
    chk("R2 explicit fold", 32'(outData), 32'h0_8D14);
    @(negedge clk);
    chk("R3 single pulse", 32'(outValid), 0);
  endtask

  task automatic testPriming();
    doReset();
    outSel = 1'b1; strobeEn = 1'b0; shiftSel = 2'd0; delaySel = 3'd2;
    for (int k = 0; k < 6; k++) sendNow(18'(k * 1000 + k * k * 37), "R6 R4 span3");
  endtask

  task automatic testWrap();
    doReset();
    outSel = 1'b1; strobeEn = 1'b0; shiftSel = 2'd0; delaySel = 3'd0;
    sendNow(18'h3FFF0, "R6 first");
    inPhase = 18'h00010; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R5 wrap up valid", 32'(outValid), 1);
    chk("R5 wrap up", 32'(outData), 32'h00020);
    inPhase = 18'h3FFF0; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R5 wrap down", 32'(outData), 32'h3FFE0);
  endtask

  task automatic testGaps();
    doReset();
    outSel = 1'b1; strobeEn = 1'b1; shiftSel = 2'd0; delaySel = 3'd1;
    sendNow(18'h00100, "R7 a");
    idle(3);
    sendNow(18'h00300, "R7 b");
    idle(2);
    sendNow(18'h00700, "R7 c");
    idle(1);
    sendNow(18'h00F00, "R7 d");
  endtask

  task automatic testStrobe();
    doReset();
    outSel = 1'b0; strobeEn = 1'b1; shiftSel = 2'd1; delaySel = 3'd0;
    for (int k = 0; k < 4; k++) sendNow(18'(k * 5001 + 77), "R8 strobe");
    strobeEn = 1'b0;
    for (int k = 0; k < 2; k++) sendNow(18'(k * 333), "R8 strobe off");
    outSel = 1'b1; strobeEn = 1'b1;
    for (int k = 0; k < 3; k++) sendNow(18'(k * 9000 + 5), "R8 both");
  endtask

  task automatic testShiftHistory();
    doReset();
    outSel = 1'b1; strobeEn = 1'b1; delaySel = 3'd0;
    shiftSel = 2'd0;
    sendNow(18'h10000, "R9 unfolded");
    shiftSel = 2'd1;
    // folded now 0x00000+... : 0x10001<<1 = 0x20002; minus 0x10000 = 0x10002
    inPhase = 18'h10001; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 mixed fold diff", 32'(outData), 32'h10002);
    chk("R9 mixed fold rate", 32'(rateData), 32'h10002);
    mHist[0] = 18'h20002; mHist[1] = 18'h10000; mCount = 2;
    shiftSel = 2'd3;
    for (int k = 0; k < 3; k++) sendNow(18'(k * 4321 + 1), "R9 run");
  endtask

  task automatic testLongSpan();
    doReset();
    outSel = 1'b1; strobeEn = 1'b1; shiftSel = 2'd2; delaySel = 3'd7;
    for (int k = 0; k < 11; k++) begin
      sendNow(18'(k * 7919 + 3), "R4 R6 span8");
      if (k == 4) idle(2);
    end
    delaySel = 3'd4;
    for (int k = 0; k < 3; k++) sendNow(18'(k * 111), "R4 span change");
  endtask

  initial begin
    testFoldPhase();
    testPriming();
    testWrap();
    testGaps();
    testStrobe();
    testShiftHistory();
    testLongSpan();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule